// File: doc/BRIEF.md
# Split Sub-Vector Element Offset Sequencer

This block walks the element offsets of a vectorised move in which the source and the destination each carry their own sub-vector length. A start pulse takes a snapshot of the vector length, the two sub-vector lengths and the ordering mode. After that the block presents one source offset and one destination offset per cycle. A consumer takes each pair with a ready/valid handshake. A last flag marks the final pair, and the block then drops back to idle on its own.

In split order each side runs its own pair of counters. The sub-vector counter is the outer loop and the vector counter is the inner loop, so each offset is the inner count plus the vector length times the outer count. The two sides step together and the run stops when the shorter side is exhausted. Setting one side's length to 1 and the other's to 2..4 gives the pack or the unpack case. In interleaved order the vector counter is the outer loop and the sub-vector counter is the inner loop, with one sub-vector length for both sides. The block produces offsets only: addressing, data movement, masking and element widths belong to the logic around it.

Top module: `elem_idx_seq`

## Requirements
- R1: After reset, `valid_o` and `last_o` are 0.
- R2: A `start_i` pulse while idle with a nonzero `vl_i` makes `valid_o` 1 on the next cycle, with both offsets at 0.
- R3: With `split_i`=1, each side counts an outer index j over its own sub-vector length and an inner index i over 0..VL-1, and presents offset i + VL*j. The source side uses `src_len_i` and the destination side uses `dst_len_i`. Both step once per accepted pair (`valid_o` and `ready_i` both 1).
- R4: With `split_i`=0, an outer index i runs over 0..VL-1 and an inner index j runs over the length given by `dst_len_i`. Both offsets equal i*L + j.
- R5: A 2-bit length code c means length c+1. A run yields VL*min(Ls,Ld) pairs in split order and VL*Ld pairs in interleaved order.
- R6: `last_o` is 1 only on the final pair. Once that pair is accepted, `valid_o` is 0 on the next cycle.
- R7: While `valid_o` is 1 and `ready_i` is 0, the offsets, `valid_o` and `last_o` hold their values.
- R8: A `start_i` pulse while a run is active is ignored. This includes the cycle in which the final pair is accepted.
- R9: A start with `vl_i`=0 produces no valid output, and the block stays idle.
- R10: The mode, VL and length inputs are sampled only at start. Changing them during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| split_i | input | 1 | 1 = split sub-vector-outer order, 0 = interleaved order |
| vl_i | input | VL_W | Vector length |
| src_len_i | input | 2 | Source sub-vector length code (length = code+1) |
| dst_len_i | input | 2 | Destination sub-vector length code (length = code+1) |
| ready_i | input | 1 | Consumer accepts the current pair |
| valid_o | output | 1 | Offset pair is valid |
| last_o | output | 1 | Current pair is the final one |
| src_off_o | output | VL_W+2 | Source element offset |
| dst_off_o | output | VL_W+2 | Destination element offset |

## Verification
A start request can arrive in the same cycle as the acceptance of the final pair. Completion must win: the block goes idle and the request is dropped rather than restarting the run. The bench provokes this by raising `start_i` with a fresh configuration while `last_o` and `ready_i` are both high. It then judges that `valid_o` is low on the following cycle. A second collision, a start in the middle of a run, is judged by checking that the offset sequence continues without a reset to 0.

// File: rtl/elem_idx_pkg.sv
package elem_idx_pkg;
  localparam int LEN_W = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  typedef struct packed {
    logic             split;
    logic [LEN_W-1:0] src_len;
    logic [LEN_W-1:0] dst_len;
  } len_cfg_t;
endpackage

// File: rtl/elem_idx_side.sv
module elem_idx_side
  import elem_idx_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic                 split_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic [VL_W+LEN_W-1:0] off_o,
  output logic                 end_o
);
  localparam int OFF_W = VL_W + LEN_W;

  logic [VL_W-1:0]  vcnt_q, vcnt_d;
  logic [LEN_W-1:0] scnt_q, scnt_d;
  logic             v_wrap, s_wrap;

  assign v_wrap = (vcnt_q == vl_i - VL_W'(1));
  assign s_wrap = (scnt_q == len_i);
  assign end_o  = v_wrap && s_wrap;

  // next-state: split order wraps the vector count first
  always_comb begin
    vcnt_d = vcnt_q;
    scnt_d = scnt_q;
    if (load_i) begin
      vcnt_d = '0;
      scnt_d = '0;
    end else if (step_i) begin
      if (split_i) begin
        if (v_wrap) begin
          vcnt_d = '0;
          scnt_d = scnt_q + LEN_W'(1);
        end else begin
          vcnt_d = vcnt_q + VL_W'(1);
        end
      end else begin
        if (s_wrap) begin
          scnt_d = '0;
          vcnt_d = vcnt_q + VL_W'(1);
        end else begin
          scnt_d = scnt_q + LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0;
      scnt_q <= '0;
    end else if (load_i || step_i) begin
      vcnt_q <= vcnt_d;
      scnt_q <= scnt_d;
    end
  end

  always_comb begin
    if (split_i) begin
      off_o = OFF_W'(vcnt_q) + OFF_W'(vl_i) * OFF_W'(scnt_q);
    end else begin
      off_o = OFF_W'(vcnt_q) * OFF_W'({1'b0, len_i} + 3'd1) + OFF_W'(scnt_q);
    end
  end
endmodule

// File: rtl/elem_idx_ctrl.sv
module elem_idx_ctrl
  import elem_idx_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  len_cfg_t        cfg_i,
  input  logic            ready_i,
  input  logic            any_end_i,
  output logic            load_o,
  output logic            step_o,
  output logic            valid_o,
  output logic            last_o,
  output logic [VL_W-1:0] vl_o,
  output len_cfg_t        cfg_o
);
  seq_state_t state_q, state_d;
  logic       take;

  assign valid_o = (state_q == ST_RUN);
  assign last_o  = valid_o && any_end_i;
  assign take    = valid_o && ready_i;
  assign load_o  = (state_q == ST_IDLE) && start_i && (vl_i != '0);
  assign step_o  = take && !any_end_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load_o) state_d = ST_RUN;
      ST_RUN:  if (take && any_end_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // configuration snapshot, enabled only at an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_o  <= '0;
      cfg_o <= '0;
    end else if (load_o) begin
      vl_o  <= vl_i;
      cfg_o <= cfg_i;
    end
  end
endmodule

// File: rtl/elem_idx_seq.sv
module elem_idx_seq
  import elem_idx_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 split_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic [1:0]           src_len_i,
  input  logic [1:0]           dst_len_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic                 last_o,
  output logic [VL_W+1:0]      src_off_o,
  output logic [VL_W+1:0]      dst_off_o
);
  localparam int OFF_W  = VL_W + LEN_W;
  localparam int NSIDES = 2;

  len_cfg_t        cfg_in, cfg_q;
  logic [VL_W-1:0] vl_q;
  logic            load, step;
  logic [NSIDES-1:0]      side_end;
  logic [LEN_W-1:0]       side_len [NSIDES];
  logic [OFF_W-1:0]       side_off [NSIDES];

  assign cfg_in = '{split: split_i, src_len: src_len_i, dst_len: dst_len_i};

  // interleaved order uses one length for both sides
  assign side_len[0] = cfg_q.split ? cfg_q.src_len : cfg_q.dst_len;
  assign side_len[1] = cfg_q.dst_len;

  elem_idx_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .vl_i      (vl_i),
    .cfg_i     (cfg_in),
    .ready_i   (ready_i),
    .any_end_i (|side_end),
    .load_o    (load),
    .step_o    (step),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .vl_o      (vl_q),
    .cfg_o     (cfg_q)
  );

  for (genvar g = 0; g < NSIDES; g++) begin : g_side
    elem_idx_side #(.VL_W(VL_W)) u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .step_i  (step),
      .split_i (cfg_q.split),
      .vl_i    (vl_q),
      .len_i   (side_len[g]),
      .off_o   (side_off[g]),
      .end_o   (side_end[g])
    );
  end

  assign src_off_o = side_off[0];
  assign dst_off_o = side_off[1];
endmodule

// File: rtl/elem_idx_seq_chk.sv
module elem_idx_seq_chk #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [VL_W-1:0] vl_i,
  input logic            ready_i,
  input logic            valid_o,
  input logic            last_o,
  input logic [VL_W+1:0] src_off_o,
  input logic [VL_W+1:0] dst_off_o
);
  // R2
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i && vl_i != '0) |=> (valid_o && src_off_o == '0 && dst_off_o == '0));

  // R3 / R4 / R8: an accepted non-final pair advances both offsets by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !last_o) |=>
      (valid_o && src_off_o == $past(src_off_o) + (VL_W+2)'(1)
               && dst_off_o == $past(dst_off_o) + (VL_W+2)'(1)));

  // R6
  a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o) |=> !valid_o);

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=>
      (valid_o && $stable(src_off_o) && $stable(dst_off_o) && $stable(last_o)));

  // R9
  a_r9_zero_vl: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i && vl_i == '0) |=> !valid_o);
endmodule

bind elem_idx_seq elem_idx_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .vl_i      (vl_i),
  .ready_i   (ready_i),
  .valid_o   (valid_o),
  .last_o    (last_o),
  .src_off_o (src_off_o),
  .dst_off_o (dst_off_o)
);

// File: tb/elem_idx_seq_bench.sv
module elem_idx_seq_bench;
  localparam int VL_W  = 7;
  localparam int OFF_W = VL_W + 2;
  localparam int NV    = 8;
  // {split, vl[6:0], src code[1:0], dst code[1:0]}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 7'd5, 2'd0, 2'd2},   // pack
    {1'b1, 7'd3, 2'd3, 2'd0},   // unpack
    {1'b1, 7'd2, 2'd1, 2'd3},
    {1'b1, 7'd1, 2'd3, 2'd3},
    {1'b0, 7'd4, 2'd2, 2'd1},
    {1'b0, 7'd3, 2'd0, 2'd0},
    {1'b0, 7'd7, 2'd1, 2'd3},
    {1'b1, 7'd6, 2'd1, 2'd1}
  };

  logic clk, rst_n, start_i, split_i, ready_i;
  logic [VL_W-1:0] vl_i;
  logic [1:0] src_len_i, dst_len_i;
  logic valid_o, last_o;
  logic [OFF_W-1:0] src_off_o, dst_off_o;
  int n_chk, n_fail;

  elem_idx_seq #(.VL_W(VL_W)) u_elem_idx_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .split_i(split_i),
    .vl_i(vl_i), .src_len_i(src_len_i), .dst_len_i(dst_len_i),
    .ready_i(ready_i), .valid_o(valid_o), .last_o(last_o),
    .src_off_o(src_off_o), .dst_off_o(dst_off_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_off(input bit sp, input int vl, input int len, input int k);
    if (sp) return (k % vl) + vl * (k / vl);   // i inner, j outer
    return (k / len) * len + (k % len);        // i outer, j inner
  endfunction

  task automatic begin_run(input bit sp, input int vl, input int sc, input int dc);
    @(negedge clk);
    start_i = 1'b1; split_i = sp; vl_i = VL_W'(vl);
    src_len_i = 2'(sc); dst_len_i = 2'(dc); ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble config inputs once the run is under way
    split_i = ~sp; vl_i = ~VL_W'(vl); src_len_i = ~2'(sc); dst_len_i = ~2'(dc);
  endtask

  task automatic check_pair(input bit sp, input int vl, input int sc, input int dc,
                            input int k, input int n, input string tag);
    int ls = sp ? sc + 1 : dc + 1;
    int ld = dc + 1;
    chk(valid_o == 1'b1, {tag, " R2 valid"}, int'(valid_o), 1);
    chk(int'(src_off_o) == exp_off(sp, vl, ls, k), {tag, " src offset R10"},
        int'(src_off_o), exp_off(sp, vl, ls, k));
    chk(int'(dst_off_o) == exp_off(sp, vl, ld, k), {tag, " dst offset"},
        int'(dst_off_o), exp_off(sp, vl, ld, k));
    chk(last_o == (k == n - 1), "R6 last position", int'(last_o), int'(k == n - 1));
  endtask

  function automatic int run_len(input bit sp, input int vl, input int sc, input int dc);
    int m = (sc < dc) ? sc : dc;
    return sp ? vl * (m + 1) : vl * (dc + 1);
  endfunction

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; split_i = 1'b0; vl_i = '0;
    src_len_i = '0; dst_len_i = '0; ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && last_o == 1'b0, "R1 reset idle", int'(valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 idle after release", int'(valid_o), 0);

    // table walk: R3 split, R4 interleaved, R5 count
    for (int v = 0; v < NV; v++) begin
      bit sp = VEC[v][11];
      int vl = int'(VEC[v][10:4]);
      int sc = int'(VEC[v][3:2]);
      int dc = int'(VEC[v][1:0]);
      int n  = run_len(sp, vl, sc, dc);
      begin_run(sp, vl, sc, dc);
      for (int k = 0; k < n; k++) begin
        check_pair(sp, vl, sc, dc, k, n, sp ? "R3" : "R4");
        @(negedge clk);
      end
      chk(valid_o == 1'b0, "R5 run length / R6 idle", int'(valid_o), 0);
    end

    // R9: zero vector length
    @(negedge clk);
    start_i = 1'b1; vl_i = '0; split_i = 1'b1; src_len_i = 2'd3; dst_len_i = 2'd3;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o == 1'b0, "R9 zero VL no valid", int'(valid_o), 0);
    @(negedge clk);
    chk(valid_o == 1'b0, "R9 stays idle", int'(valid_o), 0);

    // R7: stall holds offsets
    begin_run(1'b1, 4, 1, 1);
    @(negedge clk); @(negedge clk);
    ready_i = 1'b0;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(valid_o && int'(src_off_o) == 2 && int'(dst_off_o) == 2,
          "R7 hold under stall", int'(src_off_o), 2);
    end
    ready_i = 1'b1;
    for (int k = 2; k < 8; k++) begin
      check_pair(1'b1, 4, 1, 1, k, 8, "R7 resume");
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R7 run completes", int'(valid_o), 0);

    // R8 / R10: start mid-run with another configuration is ignored
    begin_run(1'b0, 3, 1, 1);
    @(negedge clk); @(negedge clk);
    start_i = 1'b1; split_i = 1'b1; vl_i = 7'd9; src_len_i = 2'd3; dst_len_i = 2'd3;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 3; k < 6; k++) begin
      check_pair(1'b0, 3, 1, 1, k, 6, "R8 mid-run start");
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R8 original length kept", int'(valid_o), 0);

    // R8: start in the cycle the final pair is accepted
    begin_run(1'b1, 2, 0, 0);
    @(negedge clk);
    chk(last_o == 1'b1, "R6 last on final pair", int'(last_o), 1);
    start_i = 1'b1; vl_i = 7'd3; split_i = 1'b1; src_len_i = 2'd0; dst_len_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o == 1'b0, "R8 start on final accept ignored", int'(valid_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule